// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Timing Unit

This unit sits on the data side of a 16-bit SDRAM device model or controller. It turns two per-byte mask inputs into the timing the byte lanes need. On the write side the mask works in the same cycle as the write data. A lane whose mask bit is high is not written, so that byte of the small byte-write register keeps what it held before. On the read side the mask passes through a pipeline two clocks deep. It then gates a per-lane output enable that is high only inside the read data window, and a masked lane or a cycle outside the window means the lane is not driven (high impedance).

The read window is opened by a read strobe from the command decoder, which is outside this unit. The window opens a programmable CAS latency after the strobe and lasts for a programmable burst length. A later read strobe cuts a running burst short: the beats of the old burst that come before the new burst's first beat still go out, and from that beat on the new burst's pattern applies. A registered copy of the clock-enable input decides which clock edges are valid. On an edge that follows a cycle with clock enable low, every register in the unit holds its value. The lane enables, the driven data, the mask pipeline, the window schedule and the byte register all stay as they are, and write strobes on such an edge are ignored.

Top module: `sdr_lane_mask`

## Requirements
- R1: While reset is asserted and on the first sample after it is released, `dq_oe` is 0, `dq_out` is 0 and `store_q` is 0.
- R2: `dqm[1]` governs bits 15:8 and `dqm[0]` governs bits 7:0. `lane_we[l]` is high in the same cycle exactly when the edge is valid, `wr_go` is high and `dqm[l]` is low.
- R3: On a valid edge, each lane with `lane_we` high loads its byte of `wr_data` into `store_q`, and every other lane keeps its previous byte.
- R4: A read strobe accepted on valid edge t with latency `cas_lat`=CL (1..3) and `burst_sel`=S (burst length 2^S, 1 to 8 beats) makes valid edges t+CL through t+CL+2^S-1 read beats. Edges are counted in valid edges only. After each beat edge, an unmasked lane has `dq_oe` high.
- R5: The read mask has a latency of two valid edges. After beat edge n, `dq_oe[l]` is the inverse of the `dqm[l]` value sampled at valid edge n-2, so a masked lane is high impedance.
- R6: An edge is valid only if `cke` was high at the edge before it. On an invalid edge, `dq_oe`, `dq_out`, `store_q`, the mask pipeline and the window schedule all hold, and `lane_we` is 0.
- R7: After a valid edge that is not a beat, `dq_oe` is 0 on both lanes.
- R8: A read strobe during a running burst replaces only that burst's beats at and after the new burst's first beat. Earlier beats of the old burst are still output.
- R9: On each beat edge `dq_out` loads `rd_word`. On any other edge it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low makes the next edge invalid |
| rd_go | input | 1 | Read command accepted this cycle |
| cas_lat | input | 2 | CAS latency in valid edges, 1 to 3 |
| burst_sel | input | 2 | Burst length code, length = 2^code |
| dqm | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| wr_go | input | 1 | Write data present this cycle |
| wr_data | input | 16 | Write data |
| rd_word | input | 16 | Read data from the array |
| lane_we | output | 2 | Per-lane write enable, same cycle |
| store_q | output | 16 | Byte-write register contents |
| dq_out | output | 16 | Read data being driven |
| dq_oe | output | 2 | Per-lane output enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports combines three things: a clock-enable drop in the middle of a burst, a mask change that is still travelling through the two-stage pipeline, and a second read strobe that cuts the first burst short. All three shift the mapping between mask samples and beats. A directed run issues an eight-beat read and then a two-beat read three edges later, and checks the enables edge by edge. Another directed run drops clock enable in the middle of a masked burst. A long seeded random run then mixes suspends, overlapping reads with varying latency and burst length, toggling masks and writes, and compares every cycle against a model kept in valid-edge time.

// File: rtl/sdr_mask_pkg.sv
package sdr_mask_pkg;
   localparam int DEF_LANES  = 2;
   localparam int DEF_LANE_W = 8;
   localparam int DEF_MAX_CL = 3;
   localparam int DEF_MAX_BL = 8;
   localparam int DEF_RD_LAT = 2;

   // number of beats selected by a burst code
   function automatic int beats_of(input int code);
      return 1 << code;
   endfunction

   // true when schedule slot i (i+1 edges ahead) is a beat of a new burst
   function automatic logic slot_in_burst(input int i, input int cl, input int bl);
      return (i >= cl - 1) && (i <= cl + bl - 2);
   endfunction
endpackage

// File: rtl/sdr_rd_window.sv
module sdr_rd_window #(
   parameter int MAX_CL = sdr_mask_pkg::DEF_MAX_CL,
   parameter int MAX_BL = sdr_mask_pkg::DEF_MAX_BL,
   localparam int CLW  = $clog2(MAX_CL + 1),
   localparam int BSW  = $clog2($clog2(MAX_BL) + 1),
   localparam int WIN  = MAX_CL + MAX_BL - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           rd_go,
   input  logic [CLW-1:0] cl,
   input  logic [BSW-1:0] bl_sel,
   output logic           beat
);
   logic [WIN-1:0] sched_q;
   logic [WIN-1:0] sched_d;
   logic [WIN-1:0] keep;
   logic [WIN-1:0] fresh;
   int cl_i;
   int bl_i;

   always_comb begin
      cl_i = int'(cl);
      bl_i = sdr_mask_pkg::beats_of(int'(bl_sel));
      for (int i = 0; i < WIN; i++) begin
         keep[i]  = (i < cl_i - 1);
         fresh[i] = sdr_mask_pkg::slot_in_burst(i, cl_i, bl_i);
      end
   end

   always_comb begin
      sched_d = sched_q >> 1;
      if (rd_go) sched_d = (sched_d & keep) | fresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sched_q <= '0;
      else if (adv) sched_q <= sched_d;
   end

   assign beat = sched_q[0];
endmodule

// File: rtl/sdr_mask_pipe.sv
module sdr_mask_pipe #(
   parameter int LANES  = sdr_mask_pkg::DEF_LANES,
   parameter int RD_LAT = sdr_mask_pkg::DEF_RD_LAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [LANES-1:0] dqm,
   output logic [LANES-1:0] late
);
   if (RD_LAT == 0) begin : g_direct
      assign late = dqm;
   end else begin : g_stages
      logic [LANES-1:0] stage_q [RD_LAT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < RD_LAT; s++) stage_q[s] <= '1;
         end else if (adv) begin
            stage_q[0] <= dqm;
            for (int s = 1; s < RD_LAT; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign late = stage_q[RD_LAT-1];
   end
endmodule

// File: rtl/sdr_lane_write.sv
module sdr_lane_write #(
   parameter int LANES  = sdr_mask_pkg::DEF_LANES,
   parameter int LANE_W = sdr_mask_pkg::DEF_LANE_W,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr_go,
   input  logic [LANES-1:0] dqm,
   input  logic [DW-1:0]    wr_data,
   output logic [LANES-1:0] lane_we,
   output logic [DW-1:0]    store_q
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] byte_q;
      assign lane_we[l] = adv & wr_go & ~dqm[l];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          byte_q <= '0;
         else if (lane_we[l]) byte_q <= wr_data[l*LANE_W +: LANE_W];
      end
      assign store_q[l*LANE_W +: LANE_W] = byte_q;
   end
endmodule

// File: rtl/sdr_lane_mask.sv
module sdr_lane_mask #(
   parameter int LANES  = sdr_mask_pkg::DEF_LANES,
   parameter int LANE_W = sdr_mask_pkg::DEF_LANE_W,
   parameter int MAX_CL = sdr_mask_pkg::DEF_MAX_CL,
   parameter int MAX_BL = sdr_mask_pkg::DEF_MAX_BL,
   parameter int RD_LAT = sdr_mask_pkg::DEF_RD_LAT,
   localparam int DW    = LANES * LANE_W,
   localparam int CLW   = $clog2(MAX_CL + 1),
   localparam int BSW   = $clog2($clog2(MAX_BL) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             rd_go,
   input  logic [CLW-1:0]   cas_lat,
   input  logic [BSW-1:0]   burst_sel,
   input  logic [LANES-1:0] dqm,
   input  logic             wr_go,
   input  logic [DW-1:0]    wr_data,
   input  logic [DW-1:0]    rd_word,
   output logic [LANES-1:0] lane_we,
   output logic [DW-1:0]    store_q,
   output logic [DW-1:0]    dq_out,
   output logic [LANES-1:0] dq_oe
);
   if (LANES < 1) begin : g_bad_lanes
      $error("sdr_lane_mask: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("sdr_lane_mask: LANE_W must be at least 1");
   end
   if (MAX_CL < 1) begin : g_bad_cl
      $error("sdr_lane_mask: MAX_CL must be at least 1");
   end
   if (MAX_BL < 1 || (MAX_BL & (MAX_BL - 1)) != 0) begin : g_bad_bl
      $error("sdr_lane_mask: MAX_BL must be a power of two");
   end

   logic             cke_q;
   logic             adv;
   logic             beat;
   logic [LANES-1:0] mask_late;
   logic [LANES-1:0] oe_q;
   logic [DW-1:0]    dq_q;

   // an edge is valid only if clock enable was high one cycle before
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b1;
      else        cke_q <= cke;
   end
   assign adv = cke_q;

   sdr_rd_window #(.MAX_CL(MAX_CL), .MAX_BL(MAX_BL)) i_window (
      .clk(clk), .rst_n(rst_n), .adv(adv), .rd_go(rd_go),
      .cl(cas_lat), .bl_sel(burst_sel), .beat(beat)
   );

   sdr_mask_pipe #(.LANES(LANES), .RD_LAT(RD_LAT)) i_pipe (
      .clk(clk), .rst_n(rst_n), .adv(adv), .dqm(dqm), .late(mask_late)
   );

   sdr_lane_write #(.LANES(LANES), .LANE_W(LANE_W)) i_write (
      .clk(clk), .rst_n(rst_n), .adv(adv), .wr_go(wr_go), .dqm(dqm),
      .wr_data(wr_data), .lane_we(lane_we), .store_q(store_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= '0;
         dq_q <= '0;
      end else if (adv) begin
         oe_q <= {LANES{beat}} & ~mask_late;
         if (beat) dq_q <= rd_word;
      end
   end

   assign dq_oe  = oe_q;
   assign dq_out = dq_q;
endmodule

// File: rtl/sdr_lane_mask_chk.sv
module sdr_lane_mask_chk #(
   parameter int LANES  = sdr_mask_pkg::DEF_LANES,
   parameter int LANE_W = sdr_mask_pkg::DEF_LANE_W,
   localparam int DW    = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic [LANES-1:0] dqm,
   input logic [LANES-1:0] lane_we,
   input logic [DW-1:0]    store_q,
   input logic [DW-1:0]    dq_out,
   input logic [LANES-1:0] dq_oe
);
   AST_SUSPEND_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cke, 2) |-> $stable(dq_oe)); // R6
   AST_SUSPEND_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cke, 2) |-> $stable(dq_out)); // R6
   AST_SUSPEND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cke) |-> (lane_we == '0)); // R6

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_STORE_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
         (store_q[l*LANE_W +: LANE_W] != $past(store_q[l*LANE_W +: LANE_W]))
         |-> $past(lane_we[l])); // R3
      AST_READ_MASK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(cke, 2) && $past(cke, 3) && $past(cke, 4) && dq_oe[l])
         |-> !$past(dqm[l], 3)); // R5
   end
endmodule

bind sdr_lane_mask sdr_lane_mask_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .dqm(dqm), .lane_we(lane_we),
   .store_q(store_q), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/test_sdr_lane_mask.sv
`timescale 1ns/1ps
module test_sdr_lane_mask;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_r = 1'b1;
   logic        rd_r = 1'b0;
   logic [1:0]  cl_r = 2'd2;
   logic [1:0]  bs_r = 2'd0;
   logic [1:0]  dqm_r = 2'b00;
   logic        wr_r = 1'b0;
   logic [15:0] wd_r = '0;
   logic [15:0] rw_r = '0;
   logic [1:0]  lane_we;
   logic [15:0] store_q;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;

   int n_cmp = 0;
   int n_bad = 0;
   string scn = "";

   // bench model, in valid-edge time
   logic        m_cke_q = 1'b1;
   int          ve = 0;
   bit          win [256];
   logic [1:0]  hist [256];
   logic [1:0]  e_oe = '0;
   logic [15:0] e_dq = '0;
   logic [15:0] e_st = '0;
   logic        e_en = 1'b1;
   logic        e_beat = 1'b0;

   always #10 clk = ~clk;

   sdr_lane_mask i_sdr_lane_mask (
      .clk(clk), .rst_n(rst_n), .cke(cke_r), .rd_go(rd_r), .cas_lat(cl_r),
      .burst_sel(bs_r), .dqm(dqm_r), .wr_go(wr_r), .wr_data(wd_r),
      .rd_word(rw_r), .lane_we(lane_we), .store_q(store_q),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, scn, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] mask_at(input int n);
      if (n < 0) return 2'b11;
      return hist[n % 256];
   endfunction

   task automatic cyc();
      logic [1:0] exp_we;
      #1;
      exp_we = (m_cke_q && wr_r) ? ~dqm_r : 2'b00;
      chk(lane_we == exp_we, "R2", 32'(lane_we), 32'(exp_we));
      @(posedge clk);
      e_en = m_cke_q;
      m_cke_q = cke_r;
      e_beat = 1'b0;
      if (e_en) begin
         e_beat = win[ve % 256];
         win[ve % 256] = 1'b0;
         e_oe = e_beat ? ~mask_at(ve - 2) : 2'b00;
         if (e_beat) e_dq = rw_r;
         hist[ve % 256] = dqm_r;
         if (rd_r) begin
            for (int e = ve + int'(cl_r); e <= ve + 11; e++) win[e % 256] = 1'b0;
            for (int k = 0; k < (1 << bs_r); k++) win[(ve + int'(cl_r) + k) % 256] = 1'b1;
         end
         if (wr_r) begin
            if (!dqm_r[0]) e_st[7:0]  = wd_r[7:0];
            if (!dqm_r[1]) e_st[15:8] = wd_r[15:8];
         end
         ve++;
      end
      @(negedge clk);
      chk(dq_oe == e_oe, !e_en ? "R6" : (e_beat ? ((e_oe != 2'b11) ? "R5" : "R4") : "R7"),
          32'(dq_oe), 32'(e_oe));
      chk(dq_out == e_dq, e_en ? "R9" : "R6", 32'(dq_out), 32'(e_dq));
      chk(store_q == e_st, "R3", 32'(store_q), 32'(e_st));
   endtask

   task automatic idle(input int n);
      rd_r = 1'b0; wr_r = 1'b0; cke_r = 1'b1; dqm_r = 2'b00;
      for (int i = 0; i < n; i++) begin
         rw_r = 16'($urandom);
         cyc();
      end
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [1:0]  seen [9];
      logic [1:0]  want [9];
      logic [15:0] held;
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 256; i++) begin win[i] = 1'b0; hist[i] = 2'b11; end
      repeat (4) @(negedge clk);
      scn = "reset";
      chk(dq_oe == 2'b00, "R1", 32'(dq_oe), 0);
      chk(dq_out == 16'h0, "R1", 32'(dq_out), 0);
      chk(store_q == 16'h0, "R1", 32'(store_q), 0);
      rst_n = 1'b1;
      #1;
      chk(dq_oe == 2'b00 && dq_out == 16'h0 && store_q == 16'h0, "R1",
          {dq_oe, dq_out[13:0]}, 0);
      @(negedge clk);
      idle(3);

      // directed: byte writes per lane
      scn = "lane writes";
      wr_r = 1'b1; wd_r = 16'hA1B2; dqm_r = 2'b00; cyc();
      wd_r = 16'h3344; dqm_r = 2'b01; cyc();
      chk(store_q == 16'h33B2, "R3", 32'(store_q), 32'h33B2);
      wd_r = 16'h5566; dqm_r = 2'b10; cyc();
      chk(store_q == 16'h3366, "R2", 32'(store_q), 32'h3366);
      wd_r = 16'hFFFF; dqm_r = 2'b11; cyc();
      chk(store_q == 16'h3366, "R3", 32'(store_q), 32'h3366);
      idle(2);

      // directed: interrupted burst
      scn = "interrupt";
      want = '{2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00};
      for (int k = 0; k < 9; k++) begin
         rd_r = (k == 0) || (k == 3);
         cl_r = 2'd2;
         bs_r = (k == 0) ? 2'd3 : 2'd1;
         rw_r = 16'($urandom);
         cyc();
         seen[k] = dq_oe;
      end
      rd_r = 1'b0;
      for (int k = 0; k < 9; k++)
         chk(seen[k] == want[k], "R8", 32'(seen[k]), 32'(want[k]));
      idle(4);

      // directed: suspend during masked burst
      scn = "suspend";
      rd_r = 1'b1; cl_r = 2'd3; bs_r = 2'd2; dqm_r = 2'b01; cyc();
      rd_r = 1'b0;
      for (int k = 0; k < 4; k++) begin rw_r = 16'($urandom); cyc(); end
      cke_r = 1'b0;
      rw_r = 16'($urandom); cyc();
      held = dq_out;
      for (int k = 0; k < 3; k++) begin
         rw_r = 16'($urandom); wr_r = 1'b1; dqm_r = 2'b00; cyc();
         chk(dq_out == held, "R6", 32'(dq_out), 32'(held));
      end
      wr_r = 1'b0; cke_r = 1'b1;
      idle(10);

      // constrained random
      scn = "random";
      for (int i = 0; i < 4000; i++) begin
         cke_r = ($urandom_range(99) < 85);
         rd_r  = ($urandom_range(99) < 15);
         cl_r  = 2'($urandom_range(3, 1));
         bs_r  = 2'($urandom_range(3));
         dqm_r = 2'($urandom);
         wr_r  = ($urandom_range(99) < 40);
         wd_r  = 16'($urandom);
         rw_r  = 16'($urandom);
         cyc();
      end
      idle(16);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule